// File: doc/BRIEF.md
# Multi-Mode UART Bit Timer

This block produces the bit-timing strobes for a UART that keeps the classic 16550 register layout and timing but also offers faster modes. It holds the divisor latch, a line-control byte (for its divisor-access bit), a timing-mode selector, a per-bit tick count and a sample index. A word-addressed write/read port programs these values. All fields are eight bits wide or fewer, so the data lanes carry one byte, held in the low bits of each 32-bit register word.

The block has three outputs: an oversample tick `os_tick`, a bit-boundary tick `bit_tick` that marks the last oversample tick of each bit, and a sample strobe `samp_tick` that a receiver uses to capture the line level. Software works out the divisor and sample values. The block only counts clocks.

Top module: `uart_bit_timer`

## Requirements
- R1: After reset, these registers read back as follows: line-control 0x00, timing mode 0, tick count 0x00, sample index 0xFF. The divisor reads 0x0001: low byte 0x01 and high byte 0x00, read with the access bit set.
- R2: Word index 3 holds line control (8 bits). Word 9 holds the timing mode, 2 bits, read zero-extended. Word 10 holds the tick count (8 bits). Word 11 holds the sample index (8 bits). Each reads back what was last written to it. Any unlisted word index reads 0x00, and writes to it change nothing.
- R3: When line-control bit 7 is 1, word 0 accesses the divisor low byte and word 1 accesses the divisor high byte. When bit 7 is 0, writes to words 0 and 1 leave the divisor unchanged and reads of them return 0x00. Writing 0x83 and then 0x03 keeps the divisor and leaves line control reading 0x03.
- R4: `os_tick` pulses once every D clock cycles. D is the divisor, and a divisor of 0 counts as 1.
- R5: A bit lasts N oversample ticks. N is 16 for mode 0 or 1, 4 for mode 2, and tick count + 1 for mode 3. `bit_tick` rises only together with the N-th `os_tick` of each bit.
- R6: In mode 3 with a sample index S other than 0xFF, `samp_tick` rises together with the oversample tick of 0-based index S within the bit. If S is greater than the tick count, it never rises.
- R7: In mode 3 with S = 0xFF, and in modes 0, 1 and 2 whatever S is, `samp_tick` rises on oversample index floor(N/2).
- R8: Writing the divisor (with the access bit set), the mode, the tick count or the sample index restarts the timing. Count clock edges from the write edge: `os_tick` is first high in the cycle that ends at edge D, and `bit_tick` is first high in the cycle that ends at edge N·D.
- R9: All three strobes are low while reset is asserted. Whenever a strobe's period is longer than one cycle, each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word index of the register access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| os_tick | output | 1 | Oversample tick |
| bit_tick | output | 1 | Last oversample tick of each bit |
| samp_tick | output | 1 | Mid-bit sample strobe |

## Verification
A wrong prescaler value moves every `os_tick` pulse. That error appears within one divisor period after the write that restarts timing. A wrong oversample index, or a wrong bound for it, shifts `bit_tick` and `samp_tick` relative to the oversample ticks, and this appears within one bit period. For each configuration, the bench compares all three strobes in every cycle against a model that counts from the restarting write, over three bit periods. Register corruption shows up immediately on read-back through the divisor-access window.

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              samp_tick
);
  localparam logic [ADDR_W-1:0] A_DLO  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DHI  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LCR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_SPT  = ADDR_W'(11);

  logic [7:0]  lcr, cnt, spt;
  logic [15:0] dl;
  logic [1:0]  mode;
  logic [15:0] pre;
  logic [7:0]  idx;

  wire dlab = lcr[7];
  wire dl_wr = wr_en && dlab && (addr == A_DLO || addr == A_DHI);
  wire cfg_wr = dl_wr || (wr_en && (addr == A_MODE || addr == A_CNT || addr == A_SPT));

  wire [15:0] div_eff = (dl == 16'd0) ? 16'd1 : dl;
  wire [8:0]  cnt_p1  = {1'b0, cnt} + 9'd1;

  logic [7:0] last_idx, def_samp;
  always_comb begin
    case (mode)
      2'd2:    begin last_idx = 8'd3;  def_samp = 8'd2; end
      2'd3:    begin last_idx = cnt;   def_samp = cnt_p1[8:1]; end
      default: begin last_idx = 8'd15; def_samp = 8'd8; end
    endcase
  end
  wire [7:0] samp_idx = (mode == 2'd3 && spt != 8'hFF) ? spt : def_samp;

  assign os_tick   = rst_n && (pre == div_eff - 16'd1);
  assign bit_tick  = os_tick && (idx == last_idx);
  assign samp_tick = os_tick && (idx == samp_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr  <= 8'h00;
      dl   <= 16'h0001;
      mode <= 2'd0;
      cnt  <= 8'h00;
      spt  <= 8'hFF;
    end else if (wr_en) begin
      if (addr == A_LCR) lcr <= wdata;
      if (dlab && addr == A_DLO) dl[7:0]  <= wdata;
      if (dlab && addr == A_DHI) dl[15:8] <= wdata;
      if (addr == A_MODE) mode <= wdata[1:0];
      if (addr == A_CNT)  cnt  <= wdata;
      if (addr == A_SPT)  spt  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= 16'd0;
      idx <= 8'd0;
    end else if (cfg_wr) begin
      pre <= 16'd0;
      idx <= 8'd0;
    end else if (os_tick) begin
      pre <= 16'd0;
      idx <= bit_tick ? 8'd0 : idx + 8'd1;
    end else begin
      pre <= pre + 16'd1;
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      A_DLO:  rdata = dlab ? dl[7:0]  : 8'h00;
      A_DHI:  rdata = dlab ? dl[15:8] : 8'h00;
      A_LCR:  rdata = lcr;
      A_MODE: rdata = {6'd0, mode};
      A_CNT:  rdata = cnt;
      A_SPT:  rdata = spt;
      default: rdata = 8'h00;
    endcase
  end

  // R5: bit boundary only on an oversample tick
  a_r5_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
  // R6/R7: sample strobe only on an oversample tick
  a_r6_samp_on_os: assert property (@(posedge clk) disable iff (!rst_n)
    samp_tick |-> os_tick);
  // R8: a configuration write restarts both counters
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (pre == 16'd0 && idx == 8'd0));
  // R4: the prescaler advances by one between ticks
  a_r4_prescale_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !os_tick) |=> pre == $past(pre) + 16'd1);
  // R3: the divisor changes only through the access window
  a_r3_dl_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_wr |=> $stable(dl));
  // R5: the in-bit index never passes the bit bound
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !$past(cfg_wr)) |-> idx <= last_idx);
endmodule

// File: tb/test_uart_bit_timer.sv
module test_uart_bit_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic os_tick, bit_tick, samp_tick;
  int n_tests = 0, n_fail = 0;

  uart_bit_timer #(.ADDR_W(4)) i_uart_bit_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .os_tick(os_tick), .bit_tick(bit_tick), .samp_tick(samp_tick));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int nper(int m, int c);
    if (m == 2) return 4;
    if (m == 3) return c + 1;
    return 16;
  endfunction

  function automatic int sidx(int m, int c, int s);
    if (m == 3 && s != 255) return s;
    return nper(m, c) / 2;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, int a, int exp);
    @(negedge clk);
    addr = 4'(a);
    #1;
    check(req, int'(rdata), exp);
  endtask

  // Called right after the restarting write; current negedge is cycle 0.
  task automatic run_timing(int dlv, int m, int c, int s);
    int d, n, si, bad_os, bad_bit, bad_s, first_bad;
    d = (dlv == 0) ? 1 : dlv;
    n = nper(m, c);
    si = sidx(m, c, s);
    bad_os = 0; bad_bit = 0; bad_s = 0; first_bad = -1;
    for (int j = 0; j < 3 * n * d; j++) begin
      logic e_os, e_bit, e_s;
      int k;
      e_os = ((j + 1) % d) == 0;
      k = (j / d) % n;
      e_bit = e_os && (k == n - 1);
      e_s = e_os && (k == si);
      if (os_tick !== e_os) begin bad_os++; if (first_bad < 0) first_bad = j; end
      if (bit_tick !== e_bit) bad_bit++;
      if (samp_tick !== e_s) bad_s++;
      @(negedge clk);
    end
    if (bad_os != 0) $display("  config div=%0d mode=%0d cnt=%0d sp=%0d first os mismatch cycle %0d", dlv, m, c, s, first_bad);
    check("R4/R8 os_tick mismatching cycles", bad_os, 0);
    check("R5/R8 bit_tick mismatching cycles", bad_bit, 0);
    check((m == 3 && s != 255) ? "R6 samp_tick mismatching cycles" : "R7 samp_tick mismatching cycles", bad_s, 0);
  endtask

  task automatic configure(int dlv, int m, int c, int s);
    wr(3, 8'h83);
    wr(0, dlv & 255);
    wr(1, dlv >> 8);
    wr(3, 8'h03);
    wr(10, c);
    wr(11, s);
    wr(9, m);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 2 + 1);
    // R9: strobes low in reset
    check("R9 strobes in reset", int'({os_tick, bit_tick, samp_tick}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    rd_check("R1 lcr reset", 3, 8'h00);
    rd_check("R1 mode reset", 9, 0);
    rd_check("R1 count reset", 10, 0);
    rd_check("R1 point reset", 11, 8'hFF);
    wr(3, 8'h80);
    rd_check("R1 divisor low reset", 0, 1);
    rd_check("R1 divisor high reset", 1, 0);
    // R3: divisor access window
    wr(0, 8'h34);
    wr(1, 8'h12);
    wr(3, 8'h03);
    rd_check("R3 lcr after 0x03", 3, 8'h03);
    rd_check("R3 word0 without access bit", 0, 0);
    wr(0, 8'h55);
    wr(1, 8'h66);
    wr(3, 8'h83);
    rd_check("R3 divisor low kept", 0, 8'h34);
    rd_check("R3 divisor high kept", 1, 8'h12);
    // R2: readback and unlisted offsets
    wr(10, 8'hA5);
    rd_check("R2 count readback", 10, 8'hA5);
    wr(11, 8'h3C);
    rd_check("R2 point readback", 11, 8'h3C);
    wr(9, 8'hFE);
    rd_check("R2 mode readback 2 bits", 9, 2);
    wr(5, 8'h77);
    rd_check("R2 unlisted offset", 5, 0);
    rd_check("R2 lcr untouched", 3, 8'h83);

    // Directed timing corners
    configure(1, 0, 0, 255);  run_timing(1, 0, 0, 255);    // R5 legacy 16x
    configure(3, 2, 0, 255);  run_timing(3, 2, 0, 255);    // R5 4x
    configure(0, 2, 0, 255);  run_timing(0, 2, 0, 255);    // R4 divisor 0
    configure(2, 3, 12, 5);   run_timing(2, 3, 12, 5);     // R6 programmed point
    configure(1, 3, 7, 255);  run_timing(1, 3, 7, 255);    // R7 default in mode 3
    configure(2, 3, 4, 9);    run_timing(2, 3, 4, 9);      // R6 point beyond count
    configure(2, 0, 9, 3);    run_timing(2, 0, 9, 3);      // R7 point ignored in 16x
    configure(1, 3, 0, 255);  run_timing(1, 3, 0, 255);    // R9 one-cycle bit
    configure(2, 1, 0, 255);  run_timing(2, 1, 0, 255);    // R5 mode 1 as 16x

    // Constrained random configurations
    for (int t = 0; t < 30; t++) begin
      int m, dv, c, s;
      m  = $urandom_range(3, 0);
      dv = $urandom_range(6, 0);
      c  = $urandom_range(20, 0);
      s  = ($urandom_range(3, 0) == 0) ? 255 : $urandom_range(c + 2, 0);
      configure(dv, m, c, s);
      run_timing(dv, m, c, s);
    end

    // R8: restart mid-bit by rewriting the count
    configure(3, 3, 9, 4);
    repeat (7) @(negedge clk);
    wr(10, 9);
    run_timing(3, 3, 9, 4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule